// File: doc/BRIEF.md
# Interrupt Event Routing Table

This block turns interrupt event notifications into event-queue notifications. Each incoming event carries a source number. The block uses that number unchanged as an index into an internal table of 64-bit routing words, one word per source. When the selected word is enabled and not suppressed, the block issues a single output notification. That notification carries the destination queue group, the queue slot and the payload that the queue consumer will store. Every other event is discarded, and a sticky flag records that a discard took place.

Software maintains the table through a one-command-per-cycle configuration port. The port supports a whole-word write, a read, per-source set-valid and clear-valid commands, and a command that clears the discard flag. After every reset, the block walks the table one word per clock and suppresses every word that is currently valid. The table contents are otherwise kept, so software can re-enable sources selectively. While this walk runs, the block accepts no events and no commands. It also tags each event as an inter-processor interrupt or a device interrupt, according to where its number falls in the number space.

Top module: `evt_route_table`

## Requirements
- R1: Source number n selects table word n; no base offset is subtracted, for lookups and for configuration commands alike.
- R2: Within a 64-bit word, with bit 63 the most significant: bit 63 is valid, bits 59:56 are the queue group, bits 55:32 are the queue slot, bit 31 is the suppress (masked) bit, bits 30:0 are the payload; bits 62:60 are stored but ignored by routing.
- R3: Command codes on `cfg_op`: 0 read, 1 write, 2 set valid, 3 clear valid, 4 clear discard flag, 5 to 7 act as read. A command is taken when `cfg_req` is high and `busy` is low. One cycle later `cfg_ack` pulses. For an in-range source, `cfg_ok` is 1 and `cfg_rdata` returns the word as it stood before the command. A write replaces all 64 bits at once.
- R4: Set valid and clear valid change only bit 63 of the addressed word; every other bit keeps its value.
- R5: A source number at or above `NUM_SRC` is out of range. A command on such a number returns `cfg_ok` 0 and `cfg_rdata` 0 and changes no word. An event with such a number is discarded.
- R6: An event is taken when `ntf_valid` and `ntf_ready` are both high. If its word is valid and not suppressed, `out_valid` rises one cycle later with the group, slot and payload fields of that word.
- R7: `out_valid` and its fields hold steady until `out_ready` is high. `ntf_ready` is high only while `busy` is low and the output is empty or being drained in that cycle.
- R8: An event that is taken and whose word is invalid or suppressed, or that is out of range, produces a one-cycle `drop_pulse` one cycle later and sets `drop_flag`. The flag stays set until command 4 is taken; a discard in the same cycle as that command wins.
- R9: After reset is released, `busy` stays high for exactly `NUM_SRC` cycles. During that window every valid word gets its suppress bit set and every invalid word is left as it was. No event or command is taken while `busy` is high.
- R10: `out_dev`, which is meaningful with `out_valid` or `drop_pulse`, is 1 when the event's source number is at or above `IPI_LIMIT` (default 4096) and 0 below it.
- R11: An event taken in the same cycle as a command that changes the same word is looked up against the word as it was before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the suppress walk |
| ntf_valid | input | 1 | Event offered |
| ntf_src | input | SRC_W | Source number of the offered event |
| ntf_ready | output | 1 | Event port can take an event this cycle |
| out_valid | output | 1 | Queue notification pending |
| out_ready | input | 1 | Consumer takes the pending notification |
| out_blk | output | 4 | Destination queue group |
| out_idx | output | 24 | Destination queue slot |
| out_data | output | 31 | Payload for the queue |
| out_dev | output | 1 | Event class: 1 device, 0 inter-processor |
| drop_pulse | output | 1 | One-cycle discard indication |
| drop_flag | output | 1 | Sticky discard flag |
| cfg_req | input | 1 | Command offered |
| cfg_op | input | 3 | Command code |
| cfg_src | input | SRC_W | Source number the command addresses |
| cfg_wdata | input | 64 | Word for the write command |
| cfg_ack | output | 1 | Command completed (one cycle after taking it) |
| cfg_ok | output | 1 | Command was in range or was a flag clear |
| cfg_rdata | output | 64 | Word as it stood before the command |
| busy | output | 1 | Suppress walk in progress; event and command ports closed |

## Verification
Every result lands exactly one clock edge after the edge that takes its stimulus. A notification or discard appears one edge after the event is taken, a command response one edge after the command is taken, and the end of `busy` comes `NUM_SRC` edges after reset is released. The `ntf_ready` signal is the only output that follows `out_ready` within the same cycle. The bench's reference model steps on the same edge as the design, working from the inputs held stable across that edge. The bench compares every output against the model at the falling edge, halfway through the cycle. Payload fields are compared only while `out_valid` is high, and the read word only while `cfg_ack` is high.

// File: rtl/evt_route_pkg.sv
// Shared definitions for the event routing table.
// Assumes 64-bit routing words with the field layout given in BRIEF R2.
package evt_route_pkg;

    localparam int WORD_W   = 64;
    localparam int VALID_B  = 63;
    localparam int MASK_B   = 31;
    localparam int BLK_HI   = 59;
    localparam int BLK_LO   = 56;
    localparam int SLOT_HI  = 55;
    localparam int SLOT_LO  = 32;
    localparam int DATA_HI  = 30;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_SETV    = 3'd2,
        OP_CLRV    = 3'd3,
        OP_CLRDROP = 3'd4
    } cfg_op_e;

    typedef struct packed {
        logic [BLK_HI-BLK_LO:0]   blk;
        logic [SLOT_HI-SLOT_LO:0] slot;
        logic [DATA_HI:0]         data;
    } route_t;

    // Extract the routing fields from a table word.
    function automatic route_t word_route(input logic [WORD_W-1:0] w);
        route_t r;
        r.blk  = w[BLK_HI:BLK_LO];
        r.slot = w[SLOT_HI:SLOT_LO];
        r.data = w[DATA_HI:0];
        return r;
    endfunction

endpackage

// File: rtl/ert_src_decode.sv
// Source number decoder: range check, table index and event class.
// Assumes IPI_LIMIT and NUM_SRC fit in 64 bits; out-of-range indices
// alias but are always qualified by in_range downstream.
module ert_src_decode #(
    parameter int SRC_W     = 16,
    parameter int NUM_SRC   = 64,
    parameter int IPI_LIMIT = 4096,
    parameter int IDX_W     = 6
) (
    input  logic [SRC_W-1:0] src,
    output logic             in_range,
    output logic [IDX_W-1:0] idx,
    output logic             is_dev
);

    localparam bit FULL_SPACE = (SRC_W < 31) && (NUM_SRC >= (1 << SRC_W));

    // Range check: a full number space needs no comparator.
    generate
        if (FULL_SPACE) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_cmp
            assign in_range = 64'(src) < 64'(NUM_SRC);
        end
    endgenerate

    // Index: direct low bits of the source number, no offset.
    generate
        if (SRC_W >= IDX_W) begin : g_trunc
            assign idx = src[IDX_W-1:0];
        end else begin : g_ext
            assign idx = IDX_W'(src);
        end
    endgenerate

    // Class: device interrupt at or above the inter-processor range.
    assign is_dev = 64'(src) >= 64'(IPI_LIMIT);

endmodule

// File: rtl/ert_table.sv
// Routing word storage with the post-reset suppress walk.
// Assumes the write port is only driven while busy is low; the table
// contents are not cleared by reset, only suppressed where valid.
module ert_table
    import evt_route_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              busy,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [WORD_W-1:0] rd_a_word,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [WORD_W-1:0] rd_b_word
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    logic [WORD_W-1:0] mem_q [NUM_SRC];
    logic [IDX_W-1:0]  walk_q;

    // Walk pointer and busy: restart on reset, one word per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b1;
            walk_q <= '0;
        end else if (busy) begin
            walk_q <= walk_q + 1'b1;
            if (walk_q == LAST) begin
                busy <= 1'b0;
            end
        end
    end

    // Table words: suppress valid words during the walk, else take writes.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int e = 0; e < NUM_SRC; e++) begin
                if (busy && (walk_q == IDX_W'(e))) begin
                    if (mem_q[e][VALID_B]) begin
                        mem_q[e][MASK_B] <= 1'b1;
                    end
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    mem_q[e] <= wr_word;
                end
            end
        end
    end

    // Two asynchronous read ports: event lookup and command side.
    assign rd_a_word = mem_q[rd_a_idx];
    assign rd_b_word = mem_q[rd_b_idx];

endmodule

// File: rtl/ert_lookup.sv
// Event side: takes one event per cycle, looks up its word, and either
// registers a queue notification or records a discard.
// Assumes the table read is combinational and reflects pre-edge contents.
module ert_lookup
    import evt_route_pkg::*;
#(
    parameter int SRC_W     = 16,
    parameter int NUM_SRC   = 64,
    parameter int IPI_LIMIT = 4096,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              ntf_valid,
    input  logic [SRC_W-1:0]  ntf_src,
    output logic              ntf_ready,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              clr_drop,
    output logic              out_valid,
    input  logic              out_ready,
    output route_t            out_route,
    output logic              out_dev,
    output logic              drop_pulse,
    output logic              drop_flag
);

    logic in_range;
    logic is_dev;
    logic take;
    logic hit;
    logic unused_rsv;

    ert_src_decode #(
        .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .IPI_LIMIT(IPI_LIMIT), .IDX_W(IDX_W)
    ) u_dec (
        .src(ntf_src), .in_range(in_range), .idx(rd_idx), .is_dev(is_dev)
    );

    // Handshake: open when not walking and the output slot frees up.
    assign ntf_ready = !busy && (!out_valid || out_ready);
    assign take      = ntf_valid && ntf_ready;

    // Routing decision on the selected word.
    assign hit        = in_range && rd_word[VALID_B] && !rd_word[MASK_B];
    assign unused_rsv = ^rd_word[62:60];

    // Output slot: load on a taken event, drain on out_ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_route <= '0;
            out_dev   <= 1'b0;
        end else if (take) begin
            out_valid <= hit;
            out_dev   <= is_dev;
            if (hit) begin
                out_route <= word_route(rd_word);
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Discard pulse and sticky flag; a new discard beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_pulse <= 1'b0;
            drop_flag  <= 1'b0;
        end else begin
            drop_pulse <= take && !hit;
            drop_flag  <= (drop_flag && !clr_drop) || (take && !hit);
        end
    end

endmodule

// File: rtl/ert_cfg.sv
// Command side: decodes one command per cycle into a read-modify-write
// of a single table word and returns the prior word one cycle later.
// Assumes commands are only taken while busy is low.
module ert_cfg
    import evt_route_pkg::*;
#(
    parameter int SRC_W     = 16,
    parameter int NUM_SRC   = 64,
    parameter int IPI_LIMIT = 4096,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              cfg_req,
    input  logic [2:0]        cfg_op,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_word,
    output logic              clr_drop,
    output logic              cfg_ack,
    output logic              cfg_ok,
    output logic [WORD_W-1:0] cfg_rdata
);

    logic in_range;
    logic unused_dev;
    logic take;
    logic is_clr;

    ert_src_decode #(
        .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .IPI_LIMIT(IPI_LIMIT), .IDX_W(IDX_W)
    ) u_dec (
        .src(cfg_src), .in_range(in_range), .idx(rd_idx), .is_dev(unused_dev)
    );

    assign take   = cfg_req && !busy;
    assign is_clr = (cfg_op == OP_CLRDROP);
    assign wr_idx = rd_idx;

    // Command decode: whole-word replace or single-bit valid update.
    always_comb begin
        wr_en    = 1'b0;
        wr_word  = rd_word;
        clr_drop = 1'b0;
        if (take) begin
            case (cfg_op)
                OP_WRITE: begin
                    wr_en   = in_range;
                    wr_word = cfg_wdata;
                end
                OP_SETV: begin
                    wr_en            = in_range;
                    wr_word[VALID_B] = 1'b1;
                end
                OP_CLRV: begin
                    wr_en            = in_range;
                    wr_word[VALID_B] = 1'b0;
                end
                OP_CLRDROP: clr_drop = 1'b1;
                default: wr_en = 1'b0;
            endcase
        end
    end

    // Response register: ack, status and the word before the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ack   <= 1'b0;
            cfg_ok    <= 1'b0;
            cfg_rdata <= '0;
        end else begin
            cfg_ack <= take;
            if (take) begin
                cfg_ok    <= is_clr || in_range;
                cfg_rdata <= (!is_clr && in_range) ? rd_word : '0;
            end
        end
    end

endmodule

// File: rtl/evt_route_table.sv
// Top level of the interrupt event routing table: joins the word store,
// the event lookup path and the command path.
// Assumes a single clock and synchronous active-low reset.
module evt_route_table
    import evt_route_pkg::*;
#(
    parameter int SRC_W     = 16,
    parameter int NUM_SRC   = 64,
    parameter int IPI_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid,
    input  logic [SRC_W-1:0]  ntf_src,
    output logic              ntf_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_blk,
    output logic [23:0]       out_idx,
    output logic [30:0]       out_data,
    output logic              out_dev,
    output logic              drop_pulse,
    output logic              drop_flag,
    input  logic              cfg_req,
    input  logic [2:0]        cfg_op,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_ok,
    output logic [63:0]       cfg_rdata,
    output logic              busy
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0]  a_idx;
    logic [IDX_W-1:0]  b_idx;
    logic [WORD_W-1:0] a_word;
    logic [WORD_W-1:0] b_word;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;
    logic              clr_drop;
    route_t            route;

    ert_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
        .rd_a_idx(a_idx), .rd_a_word(a_word),
        .rd_b_idx(b_idx), .rd_b_word(b_word)
    );

    ert_lookup #(
        .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .IPI_LIMIT(IPI_LIMIT), .IDX_W(IDX_W)
    ) u_lookup (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .ntf_valid(ntf_valid), .ntf_src(ntf_src), .ntf_ready(ntf_ready),
        .rd_idx(a_idx), .rd_word(a_word), .clr_drop(clr_drop),
        .out_valid(out_valid), .out_ready(out_ready), .out_route(route),
        .out_dev(out_dev), .drop_pulse(drop_pulse), .drop_flag(drop_flag)
    );

    ert_cfg #(
        .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .IPI_LIMIT(IPI_LIMIT), .IDX_W(IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .cfg_req(cfg_req), .cfg_op(cfg_op), .cfg_src(cfg_src), .cfg_wdata(cfg_wdata),
        .rd_idx(b_idx), .rd_word(b_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .clr_drop(clr_drop),
        .cfg_ack(cfg_ack), .cfg_ok(cfg_ok), .cfg_rdata(cfg_rdata)
    );

    assign out_blk  = route.blk;
    assign out_idx  = route.slot;
    assign out_data = route.data;

endmodule

// File: rtl/evt_route_chk.sv
// Property checker for the routing table, attached to every instance of
// the top module. Observes ports only.
module evt_route_chk
    import evt_route_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ntf_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [3:0]  out_blk,
    input logic [23:0] out_idx,
    input logic [30:0] out_data,
    input logic        out_dev,
    input logic        drop_pulse,
    input logic        drop_flag,
    input logic        cfg_req,
    input logic [2:0]  cfg_op,
    input logic        cfg_ack
);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_blk) &&
        $stable(out_idx) && $stable(out_data) && $stable(out_dev));

    // R7
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !ntf_ready);

    // R9
    busy_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ntf_ready);

    // R9
    busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cfg_ack);

    // R8
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag && !(cfg_req && !busy && cfg_op == OP_CLRDROP) |=> drop_flag);

    // R8
    drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> drop_flag);

    // R6
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, drop_pulse}));

endmodule

bind evt_route_table evt_route_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ntf_ready(ntf_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_blk(out_blk),
    .out_idx(out_idx), .out_data(out_data), .out_dev(out_dev),
    .drop_pulse(drop_pulse), .drop_flag(drop_flag),
    .cfg_req(cfg_req), .cfg_op(cfg_op), .cfg_ack(cfg_ack)
);

// File: tb/test_evt_route_table.sv
// Bench for evt_route_table: behavioural reference model stepped on each
// rising edge, all outputs compared at the falling edge.
module test_evt_route_table;

    localparam int SRC_W = 16;
    localparam int NUM   = 32;
    localparam int IPI   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ntf_valid = 1'b0;
    logic [15:0] ntf_src = '0;
    logic        ntf_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_blk;
    logic [23:0] out_idx;
    logic [30:0] out_data;
    logic        out_dev;
    logic        drop_pulse;
    logic        drop_flag;
    logic        cfg_req = 1'b0;
    logic [2:0]  cfg_op = '0;
    logic [15:0] cfg_src = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic        cfg_ok;
    logic [63:0] cfg_rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    evt_route_table #(.SRC_W(SRC_W), .NUM_SRC(NUM), .IPI_LIMIT(IPI)) i_evt_route_table (
        .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_src(ntf_src),
        .ntf_ready(ntf_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_blk(out_blk), .out_idx(out_idx), .out_data(out_data), .out_dev(out_dev),
        .drop_pulse(drop_pulse), .drop_flag(drop_flag), .cfg_req(cfg_req),
        .cfg_op(cfg_op), .cfg_src(cfg_src), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_ok(cfg_ok), .cfg_rdata(cfg_rdata), .busy(busy)
    );

    // ---------------- reference model ----------------
    logic [63:0] mdl [NUM];
    bit          e_busy = 1'b1;
    int          walk = 0;
    bit          e_outv = 1'b0;
    logic [3:0]  e_blk;
    logic [23:0] e_idx;
    logic [30:0] e_data;
    bit          e_dev, e_dp, e_df, e_ack, e_ok;
    logic [63:0] e_rd;

    initial for (int i = 0; i < NUM; i++) mdl[i] = '0;

    always @(posedge clk) begin
        bit tn, tc;
        int s, c;
        if (!rst_n) begin
            e_busy = 1; walk = 0; e_outv = 0; e_dp = 0; e_df = 0;
            e_ack = 0; e_ok = 0; e_rd = '0;
        end else begin
            tn = ntf_valid && !e_busy && (!e_outv || out_ready);
            tc = cfg_req && !e_busy;
            if (e_outv && out_ready) e_outv = 0;
            e_dp = 0;
            if (tc && cfg_op == 3'd4) e_df = 0;
            if (tn) begin
                s = int'(ntf_src);
                e_dev = (s >= IPI);
                if (s < NUM && mdl[s][63] && !mdl[s][31]) begin
                    e_outv = 1;
                    e_blk  = mdl[s][59:56];
                    e_idx  = mdl[s][55:32];
                    e_data = mdl[s][30:0];
                end else begin
                    e_dp = 1; e_df = 1;
                end
            end
            e_ack = tc;
            if (tc) begin
                c = int'(cfg_src);
                if (cfg_op == 3'd4) begin
                    e_ok = 1; e_rd = '0;
                end else if (c < NUM) begin
                    e_ok = 1; e_rd = mdl[c];
                    case (cfg_op)
                        3'd1: mdl[c] = cfg_wdata;
                        3'd2: mdl[c][63] = 1'b1;
                        3'd3: mdl[c][63] = 1'b0;
                        default: ;
                    endcase
                end else begin
                    e_ok = 0; e_rd = '0;
                end
            end
            if (e_busy) begin
                if (mdl[walk][63]) mdl[walk][31] = 1'b1;
                if (walk == NUM - 1) e_busy = 0;
                walk++;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // ---------------- comparison at the falling edge ----------------
    always @(negedge clk) begin
        if (!done) begin
            chk("R9 busy", 64'(busy), 64'(e_busy));
            chk("R7 R9 ntf_ready", 64'(ntf_ready), 64'(!e_busy && (!e_outv || out_ready)));
            chk("R6 out_valid", 64'(out_valid), 64'(e_outv));
            if (e_outv) begin
                chk("R1 R2 R6 R11 out_fields", {out_blk, out_idx, out_data, 5'd0},
                    {e_blk, e_idx, e_data, 5'd0});
            end
            if (e_outv || e_dp) chk("R10 out_dev", 64'(out_dev), 64'(e_dev));
            chk("R5 R8 drop_pulse", 64'(drop_pulse), 64'(e_dp));
            chk("R8 drop_flag", 64'(drop_flag), 64'(e_df));
            chk("R3 cfg_ack", 64'(cfg_ack), 64'(e_ack));
            if (e_ack) begin
                chk("R3 R5 cfg_ok", 64'(cfg_ok), 64'(e_ok));
                chk("R3 R4 R5 R9 R11 cfg_rdata", cfg_rdata, e_rd);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired: actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [63:0] mk(input int i);
        logic [63:0] w;
        w = '0;
        w[63]    = (i % 4) != 3;
        w[62:60] = 3'(i);
        w[59:56] = 4'(i % 16);
        w[55:32] = 24'(i * 32'h1111 + 5);
        w[31]    = (i % 5) == 0;
        w[30:0]  = 31'(i * 32'h0123457 + 1);
        return w;
    endfunction

    task automatic send_ntf(input int s);
        ntf_src = 16'(s);
        ntf_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (ntf_ready) break;
        end
        @(posedge clk); #1ns;
        ntf_valid = 1'b0;
    endtask

    task automatic send_cfg(input int op, input int s, input logic [63:0] d);
        cfg_op = 3'(op); cfg_src = 16'(s); cfg_wdata = d;
        cfg_req = 1'b1;
        forever begin
            @(negedge clk);
            if (!busy) break;
        end
        @(posedge clk); #1ns;
        cfg_req = 1'b0;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (!busy) break;
        end
        @(posedge clk); #1ns;
    endtask

    initial begin
        // Reset and first suppress walk (R9)
        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;
        wait_idle();
        // Load every word (R3, R2)
        for (int i = 0; i < NUM; i++) send_cfg(1, i, mk(i));
        for (int i = 0; i < 6; i++) send_cfg(0, i, '0);
        // Every source, plus out-of-range numbers (R1, R6, R8, R5, R10)
        for (int i = 0; i < NUM; i++) send_ntf(i);
        send_ntf(NUM); send_ntf(5000); send_ntf(65535);
        // Clear discard flag, then a new discard (R8)
        send_cfg(4, 0, '0);
        repeat (2) @(posedge clk); #1ns;
        send_ntf(3);
        // Back-pressure (R7)
        out_ready = 1'b0;
        send_ntf(1);
        fork
            send_ntf(2);
            begin repeat (4) @(posedge clk); #1ns out_ready = 1'b1; end
        join
        // Valid bit commands leave other fields alone (R4)
        send_cfg(3, 1, '0);
        send_ntf(1);
        send_cfg(0, 1, '0);
        send_cfg(2, 3, '0);
        send_cfg(0, 3, '0);
        send_ntf(3);
        // Out-of-range commands (R5)
        send_cfg(2, NUM, '0); send_cfg(3, 40, '0);
        send_cfg(1, 40, 64'hFFFF_FFFF_FFFF_FFFF); send_cfg(0, 40, '0);
        send_cfg(6, 7, '0);
        // Lookup and write to the same word in one cycle (R11)
        fork
            send_ntf(6);
            send_cfg(1, 6, mk(9));
        join
        send_ntf(6);
        // Discard coincident with clear: discard wins (R8)
        fork
            send_ntf(4);
            send_cfg(4, 0, '0);
        join
        // Events under a toggling consumer (R7)
        fork
            for (int i = 0; i < 16; i++) send_ntf(i);
            for (int k = 0; k < 60; k++) begin
                @(posedge clk); #1ns out_ready = (k % 3) != 0;
            end
        join
        out_ready = 1'b1;
        // Reset with requests held: suppress walk, nothing taken while busy (R9)
        ntf_valid = 1'b1; ntf_src = 16'd8;
        cfg_req = 1'b1; cfg_op = 3'd0; cfg_src = 16'd2;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1ns rst_n = 1'b1;
        wait_idle();
        ntf_valid = 1'b0; cfg_req = 1'b0;
        for (int i = 0; i < NUM; i++) send_cfg(0, i, '0);
        send_ntf(2);
        repeat (4) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule